// File: doc/BRIEF.md
# Digital frequency-lock trim controller

This block closes the frequency loop of an all-digital locked loop built around a tunable ring oscillator. It counts rising edges of the oscillator output in a Gray-coded counter. It carries that count into the reference-clock domain through a two-flop synchroniser. Over a fixed window of reference cycles, it compares the number of oscillator edges with the feedback ratio times the window length. The oscillator is too fast when it produced more edges than that target, and too slow when it produced fewer.

The loop holds its trim as a thermometer word. The oscillator adds one delay stage for each set bit. Each decision sets or clears exactly one bit at the top of the run of ones. The word saturates at empty and at full. A free-running mode passes a manually written trim word straight to the oscillator and freezes the loop. A disable input stops the oscillator and freezes the loop as well. The oscillator itself lives outside the block.

Top module: `fll_trim_ctrl`

## Requirements
- R1: While reset is asserted, `trim_out` holds the midpoint word (the 13 lowest bits set, 26'h0001FFF) and `osc_en` is 0. After reset is released, the first trim decision comes no earlier than the second window.
- R2: The loop trim word is always thermometer-coded, meaning its set bits form one run starting at bit 0. From one clock to the next it changes by at most one bit.
- R3: When the oscillator edge count over a window exceeds ratio × window, one stage is added by setting the lowest clear bit. The oscillator then slows.
- R4: When the edge count is below ratio × window, one stage is removed by clearing the highest set bit. The oscillator then speeds up.
- R5: An edge count equal to ratio × window leaves the trim unchanged. Decisions are taken once every window of 4 reference cycles, and the window that follows a change is discarded.
- R6: The trim saturates. An add request when all 26 bits are set, or a remove request when none are set, leaves the word unchanged.
- R7: Under continuous adjustment, the count of set trim bits settles to, and stays within, the band where the oscillator runs at reference × `fb_ratio`.
- R8: With `dco_mode` high, `trim_out` equals `manual_trim` (any bit pattern) one cycle later, and the loop word does not change. After `dco_mode` falls, `trim_out` returns to the held loop word.
- R9: With `enable` low, `osc_en` is 0 one cycle later and the loop trim does not change. Setting `enable` again resumes the loop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; all control logic runs on it |
| rst_n | input | 1 | Active-low asynchronous reset for both clock domains |
| osc_clk | input | 1 | Output of the tunable ring oscillator |
| enable | input | 1 | 1 runs the oscillator and the loop; 0 stops both |
| dco_mode | input | 1 | 1 drives the oscillator from `manual_trim` and freezes the loop |
| fb_ratio | input | 5 | Feedback ratio: target oscillator frequency divided by reference frequency |
| manual_trim | input | 26 | Trim word used in free-running mode |
| trim_out | output | 26 | Trim word to the oscillator; each set bit adds one delay stage |
| osc_en | output | 1 | Oscillator run enable |

## Verification
The assertions take four things for granted. `enable`, `dco_mode`, `fb_ratio` and `manual_trim` are synchronous to `clk_ref`. The oscillator edges carry no fixed phase tie to the reference edges. The synchroniser latency is shorter than the window. The edge count in one window stays below half the counter range, so that a modular difference is exact. The bench drives every control input on the falling reference edge. Its oscillator model starts at an offset of 13 ps, and all its half-periods are multiples of 50 ps, so an oscillator edge never lands on a reference edge. With at most 32 edges per window and a 9-bit counter, the count stays well inside the counter range.

// File: rtl/fll_pkg.sv
package fll_pkg;

  // Default width of the thermometer trim word (one bit per delay stage).
  localparam int unsigned FLL_TRIM_W  = 26;
  // Default width of the feedback ratio.
  localparam int unsigned FLL_RATIO_W = 5;
  // Default number of reference cycles per frequency decision.
  localparam int unsigned FLL_WIN     = 4;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_ADD  = 2'd1,
    STEP_DROP = 2'd2
  } step_e;

  // Direction of one trim decision: more edges than wanted means the
  // oscillator is fast, so a stage is added; fewer means one is dropped.
  function automatic step_e step_dir(input logic [31:0] seen,
                                     input logic [31:0] want);
    if (seen > want)      return STEP_ADD;
    else if (seen < want) return STEP_DROP;
    else                  return STEP_HOLD;
  endfunction

endpackage

// File: rtl/fll_osc_counter.sv
// Free-running edge counter in the oscillator domain, published Gray-coded
// so that the reference domain may sample it at any moment.
module fll_osc_counter #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             osc_clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] gray_q
);

  logic [CNT_W-1:0] bin_q;
  logic [CNT_W-1:0] bin_nxt;

  assign bin_nxt = bin_q + 1'b1;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_nxt;
      gray_q <= bin_nxt ^ (bin_nxt >> 1);
    end
  end

endmodule

// File: rtl/fll_gray_sync.sv
// Two-flop synchroniser of the Gray count into the reference domain,
// followed by Gray-to-binary decoding.
module fll_gray_sync #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] gray_in,
  output logic [CNT_W-1:0] bin_out
);

  logic [CNT_W-1:0] meta_q;
  logic [CNT_W-1:0] safe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      safe_q <= '0;
    end else begin
      meta_q <= gray_in;
      safe_q <= meta_q;
    end
  end

  // Each binary bit is the XOR of all Gray bits at or above it.
  for (genvar gi = 0; gi < CNT_W; gi++) begin : g_dec
    assign bin_out[gi] = ^(safe_q >> gi);
  end

endmodule

// File: rtl/fll_freq_compare.sv
// Window timer and frequency comparison. Each window end yields one
// decision, unless the loop is inactive or the window straddled a change.
module fll_freq_compare
  import fll_pkg::*;
#(
  parameter int unsigned CNT_W   = 9,
  parameter int unsigned RATIO_W = 5,
  parameter int unsigned WIN     = 4   // must exceed the synchroniser latency
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic [CNT_W-1:0]   cnt_now,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tick,
  output step_e              dir
);

  localparam int unsigned WIN_W = $clog2(WIN + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN - 1);
  localparam logic [CNT_W-1:0] WIN_C    = CNT_W'(WIN);

  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] mark_q;
  logic             skip_q;
  logic [CNT_W-1:0] delta;
  logic [CNT_W-1:0] target;
  logic             decide;

  assign tick   = (win_q == WIN_LAST);
  assign delta  = cnt_now - mark_q;
  assign target = {{(CNT_W-RATIO_W){1'b0}}, ratio} * WIN_C;
  assign decide = tick && active && !skip_q;
  assign dir    = decide ? step_dir(32'(delta), 32'(target)) : STEP_HOLD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      mark_q <= '0;
      skip_q <= 1'b1;
    end else begin
      win_q <= tick ? '0 : win_q + 1'b1;
      if (tick) mark_q <= cnt_now;
      if (!active)   skip_q <= 1'b1;
      else if (tick) skip_q <= (dir != STEP_HOLD);
    end
  end

endmodule

// File: rtl/fll_trim_stepper.sv
// Thermometer trim register: grows or shrinks by one bit at the top of the
// run of ones, saturating at both ends.
module fll_trim_stepper
  import fll_pkg::*;
#(
  parameter int unsigned TRIM_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  step_e             dir,
  output logic [TRIM_W-1:0] trim_q,
  output logic              full,
  output logic              empty
);

  localparam int unsigned      MID      = TRIM_W / 2;
  localparam logic [TRIM_W-1:0] MID_WORD = {TRIM_W{1'b1}} >> (TRIM_W - MID);

  assign full  = trim_q[TRIM_W-1];
  assign empty = !trim_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_q <= MID_WORD;
    end else begin
      unique case (dir)
        STEP_ADD:  if (!full)  trim_q <= {trim_q[TRIM_W-2:0], 1'b1};
        STEP_DROP: if (!empty) trim_q <= {1'b0, trim_q[TRIM_W-1:1]};
        default:   trim_q <= trim_q;
      endcase
    end
  end

endmodule

// File: rtl/fll_trim_ctrl.sv
module fll_trim_ctrl
  import fll_pkg::*;
#(
  parameter int unsigned TRIM_W  = FLL_TRIM_W,
  parameter int unsigned RATIO_W = FLL_RATIO_W,
  parameter int unsigned WIN     = FLL_WIN
) (
  input  logic               clk_ref,
  input  logic               rst_n,
  input  logic               osc_clk,
  input  logic               enable,
  input  logic               dco_mode,
  input  logic [RATIO_W-1:0] fb_ratio,
  input  logic [TRIM_W-1:0]  manual_trim,
  output logic [TRIM_W-1:0]  trim_out,
  output logic               osc_en
);

  // Room for four times the largest target so a modular difference is exact.
  localparam int unsigned CNT_W = $clog2((2**RATIO_W) * WIN * 4);
  localparam int unsigned MID   = TRIM_W / 2;
  localparam logic [TRIM_W-1:0] MID_WORD = {TRIM_W{1'b1}} >> (TRIM_W - MID);

  logic [CNT_W-1:0]  osc_gray;
  logic [CNT_W-1:0]  osc_cnt;
  logic              loop_active;
  logic              win_tick;
  step_e             step_dir_w;
  logic [TRIM_W-1:0] loop_trim;
  logic              trim_full;
  logic              trim_empty;
  // Named events for the checker.
  logic              step_add;
  logic              step_drop;

  assign loop_active = enable && !dco_mode;
  assign step_add    = (step_dir_w == STEP_ADD);
  assign step_drop   = (step_dir_w == STEP_DROP);

  fll_osc_counter #(.CNT_W(CNT_W)) u_cnt (
    .osc_clk (osc_clk),
    .rst_n   (rst_n),
    .gray_q  (osc_gray)
  );

  fll_gray_sync #(.CNT_W(CNT_W)) u_sync (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .gray_in (osc_gray),
    .bin_out (osc_cnt)
  );

  fll_freq_compare #(.CNT_W(CNT_W), .RATIO_W(RATIO_W), .WIN(WIN)) u_cmp (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .active  (loop_active),
    .cnt_now (osc_cnt),
    .ratio   (fb_ratio),
    .tick    (win_tick),
    .dir     (step_dir_w)
  );

  fll_trim_stepper #(.TRIM_W(TRIM_W)) u_step (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .dir    (step_dir_w),
    .trim_q (loop_trim),
    .full   (trim_full),
    .empty  (trim_empty)
  );

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      trim_out <= MID_WORD;
      osc_en   <= 1'b0;
    end else begin
      trim_out <= dco_mode ? manual_trim : loop_trim;
      osc_en   <= enable;
    end
  end

endmodule

// File: rtl/fll_trim_ctrl_chk.sv
module fll_trim_ctrl_chk #(
  parameter int unsigned TRIM_W = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              dco_mode,
  input logic [TRIM_W-1:0] manual_trim,
  input logic [TRIM_W-1:0] trim_out,
  input logic              osc_en,
  input logic [TRIM_W-1:0] loop_trim,
  input logic              step_add,
  input logic              step_drop
);

  logic started;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  a_r2_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
    (((loop_trim + 1'b1) & loop_trim) == '0));

  a_r2_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> ($countones(loop_trim ^ $past(loop_trim)) <= 1));

  a_r3_add_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step_add && !loop_trim[TRIM_W-1]) |=>
      ($countones(loop_trim) == $past($countones(loop_trim)) + 1));

  a_r4_drop_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step_drop && loop_trim[0]) |=>
      ($countones(loop_trim) + 1 == $past($countones(loop_trim))));

  a_r6_sat_full: assert property (@(posedge clk) disable iff (!rst_n)
    (step_add && loop_trim[TRIM_W-1]) |=> $stable(loop_trim));

  a_r6_sat_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (step_drop && !loop_trim[0]) |=> $stable(loop_trim));

  a_r8_manual_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(dco_mode)) |-> (trim_out == $past(manual_trim)));

  a_r8_loop_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    dco_mode |=> $stable(loop_trim));

  a_r9_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!osc_en && $stable(loop_trim)));

endmodule

bind fll_trim_ctrl fll_trim_ctrl_chk #(.TRIM_W(TRIM_W)) u_chk (
  .clk         (clk_ref),
  .rst_n       (rst_n),
  .enable      (enable),
  .dco_mode    (dco_mode),
  .manual_trim (manual_trim),
  .trim_out    (trim_out),
  .osc_en      (osc_en),
  .loop_trim   (loop_trim),
  .step_add    (step_add),
  .step_drop   (step_drop)
);

// File: tb/sim_fll_trim_ctrl.sv
`timescale 1ns/1ps
module sim_fll_trim_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc = 1'b0;
  logic        enable = 1'b1;
  logic        dco_mode = 1'b0;
  logic [4:0]  fb_ratio = 5'd4;
  logic [25:0] manual_trim = '0;
  logic [25:0] trim_out;
  logic        osc_en;

  int n_run = 0;
  int n_fail = 0;
  int mon_bad = 0;

  fll_trim_ctrl u0 (
    .clk_ref(clk), .rst_n(rst_n), .osc_clk(osc), .enable(enable),
    .dco_mode(dco_mode), .fb_ratio(fb_ratio), .manual_trim(manual_trim),
    .trim_out(trim_out), .osc_en(osc_en)
  );

  always #4 clk = ~clk;

  // Ring oscillator model: period 1.0 ns plus 0.1 ns per set trim bit.
  initial begin
    #0.013;
    forever begin
      if (osc_en) #((1.0 + 0.1 * $countones(trim_out)) / 2.0) osc = ~osc;
      else begin
        osc = 1'b0;
        @(posedge osc_en);
        #0.013;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_band(input string req, input int lo, input int hi);
    int p;
    p = $countones(trim_out);
    n_run++;
    if (p < lo || p > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, p, lo, hi);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R2 monitor: outside free-running mode the word stays thermometer and
  // moves by one bit at most.
  logic [25:0] prev_t;
  logic        dco_d1 = 1'b1, dco_d2 = 1'b1;
  always @(negedge clk) begin
    if (rst_n && !dco_mode && !dco_d1 && !dco_d2) begin
      if ((((trim_out + 26'd1) & trim_out) != 26'd0) ||
          ($countones(trim_out ^ prev_t) > 1)) mon_bad++;
    end
    prev_t <= trim_out;
    dco_d1 <= dco_mode || !rst_n;
    dco_d2 <= dco_d1;
  end

  // {ratio, lowest settled ones, highest settled ones}
  localparam bit [14:0] VEC [0:6] = '{
    {5'd4, 5'd9,  5'd11},
    {5'd9, 5'd0,  5'd0 },
    {5'd5, 5'd6,  5'd6 },
    {5'd2, 5'd26, 5'd26},
    {5'd3, 5'd15, 5'd19},
    {5'd7, 5'd1,  5'd2 },
    {5'd6, 5'd3,  5'd4 }
  };

  initial begin
    int held;
    logic [25:0] held_w;
    wait_cyc(5);
    check(trim_out == 26'h0001FFF, "R1 reset trim", int'(trim_out), 32'h1FFF);
    check(osc_en == 1'b0, "R1 osc_en in reset", int'(osc_en), 0);
    rst_n = 1'b1;
    wait_cyc(2);
    check(osc_en == 1'b1, "R1 osc_en after reset", int'(osc_en), 1);
    check(trim_out == 26'h0001FFF, "R1 no early step", int'(trim_out), 32'h1FFF);

    for (int i = 0; i < 7; i++) begin
      fb_ratio = VEC[i][14:10];
      wait_cyc(600);
      check_band("R7 settle", int'(VEC[i][9:5]), int'(VEC[i][4:0]));
      wait_cyc(40);
      check_band("R7 hold", int'(VEC[i][9:5]), int'(VEC[i][4:0]));
      if (VEC[i][14:10] == 5'd9)
        check(trim_out == 26'd0, "R6 R4 empty saturation", int'(trim_out), 0);
      if (VEC[i][14:10] == 5'd2)
        check(trim_out == 26'h3FFFFFF, "R6 R3 full saturation", int'(trim_out), 32'h3FFFFFF);
    end

    // R3: oscillator far too fast -> stages are added
    held = $countones(trim_out);
    fb_ratio = 5'd1;
    wait_cyc(20);
    check($countones(trim_out) > held, "R3 add when fast", $countones(trim_out), held + 1);
    // R4: oscillator far too slow -> stages are removed
    held = $countones(trim_out);
    fb_ratio = 5'd31;
    wait_cyc(20);
    check($countones(trim_out) < held, "R4 drop when slow", $countones(trim_out), held - 1);

    // R5: an exact count of 20 edges per window at 6 stages holds the word
    fb_ratio = 5'd5;
    wait_cyc(300);
    held_w = trim_out;
    begin
      int moved = 0;
      for (int k = 0; k < 100; k++) begin
        @(negedge clk);
        if (trim_out != held_w) moved++;
      end
      check(moved == 0 && held_w == 26'h3F, "R5 equal count holds",
            int'(held_w), 32'h3F);
    end

    // R8: free-running mode
    held_w = trim_out;
    manual_trim = 26'h2A5A5A5;
    dco_mode = 1'b1;
    @(negedge clk);
    check(trim_out == 26'h2A5A5A5, "R8 manual word", int'(trim_out), 32'h2A5A5A5);
    wait_cyc(100);
    check(trim_out == 26'h2A5A5A5, "R8 manual steady", int'(trim_out), 32'h2A5A5A5);
    manual_trim = 26'h0F0F0F0;
    @(negedge clk);
    check(trim_out == 26'h0F0F0F0, "R8 manual follows", int'(trim_out), 32'h0F0F0F0);
    dco_mode = 1'b0;
    @(negedge clk);
    check(trim_out == held_w, "R8 loop word resumes", int'(trim_out), int'(held_w));

    // R9: disable stops the oscillator and freezes the trim
    wait_cyc(50);
    held_w = trim_out;
    enable = 1'b0;
    @(negedge clk);
    check(osc_en == 1'b0, "R9 osc stopped", int'(osc_en), 0);
    wait_cyc(200);
    check(trim_out == held_w, "R9 trim held", int'(trim_out), int'(held_w));
    enable = 1'b1;
    fb_ratio = 5'd9;
    @(negedge clk);
    check(osc_en == 1'b1, "R9 osc restarted", int'(osc_en), 1);
    wait_cyc(400);
    check(trim_out == 26'd0, "R9 R6 loop resumed", int'(trim_out), 0);

    check(mon_bad == 0, "R2 thermometer single-step", mon_bad, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule